// File: doc/BRIEF.md
# Crosstalk Self-Test Phase Sequencer

This block sequences a built-in self-test for coupling faults on a combinational circuit with `NUM_IN` inputs. A run starts on a pulse of `start`. The block then works through `pat_count` pseudo-random patterns. For each pattern it spends two cycles on setup. It first advances the input chain's LFSR and clears the output error detectors. It then loads the new pattern into the chain's update stage.

After setup, the block visits every input position in turn, beginning at the least significant one. Each visit has three parts. First, a one-hot marker register shifts by one cycle. A 1 enters that register only on the first visit of each pattern. Second, a two-cycle sensitisation check holds the detection-mode enable high while the selected input is driven low and then high. Third, a square-wave window of `WIN_CYC` test-clock cycles runs with the capture, update and detect strobes all active. One pattern therefore takes `2 + NUM_IN*(3+WIN_CYC)` cycles, and the full run covers `NUM_IN*pat_count` tests.

The fault flag is the OR of all output detector flags. The block only takes it into account during square-wave windows, and it latches a sticky `fail` from it. `done` rises when the last pattern ends. A new start clears both `done` and `fail`. All pins are plain level control or status signals, so there is no valid/ready flow control.

Top module: `xbist_seq`

## Requirements
- R1: A `start` pulse while idle with `pat_count` > 0 raises `busy` from the next cycle. Each pattern begins with one cycle of `lfsr_step` and `err_clr`, followed by one cycle of `pat_load`.
- R2: Each input visit begins with one cycle of `walk_shift`. `walk_din` is 1 in that cycle only on the first visit of a pattern, where `cur_idx` is 0, and is 0 on all later visits.
- R3: After `walk_shift` come two cycles with `dm_en` and `chk_drive` high. In the first, `chk_val` is 0 and `cap_strobe` is 1. In the second, `chk_val` is 1 and `cap_strobe` is 0.
- R4: The check is followed by exactly `WIN_CYC` cycles of `sq_mode`, with `cap_strobe`, `upd_strobe` and `det_en` high in each of them.
- R5: Input visits run in rising `cur_idx` order from 0 to `NUM_IN-1`. The last window of a pattern is followed by the next pattern's setup, or by the end of the run. A run lasts `pat_count*(2+NUM_IN*(3+WIN_CYC))` cycles.
- R6: `fail` is set one cycle after `fault_flag` is high during any `sq_mode` cycle, and it stays set until the next accepted start. A `fault_flag` outside a window has no effect on `fail`.
- R7: `done` rises in the cycle after the last window ends, and `busy` falls in that same cycle. An accepted start clears `done` and `fail`. With `pat_count` = 0, `done` is set the cycle after start and no strobe fires.
- R8: A `start` pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| pat_count | input | PCW | Number of patterns, captured at start |
| fault_flag | input | 1 | OR of all output detector flags |
| lfsr_step | output | 1 | Advance the input-chain LFSR |
| err_clr | output | 1 | Reset the output error detectors |
| pat_load | output | 1 | Update-stage load of the new pattern |
| walk_shift | output | 1 | Shift the one-hot input marker |
| walk_din | output | 1 | Serial bit entering the marker register |
| dm_en | output | 1 | Detection-mode latch enable |
| chk_drive | output | 1 | Drive the check value at the marked input |
| chk_val | output | 1 | Check value (0 first, then 1) |
| cap_strobe | output | 1 | Output capture strobe |
| upd_strobe | output | 1 | Output update strobe |
| det_en | output | 1 | Detector clock enable |
| sq_mode | output | 1 | Route the square wave to the marked input |
| cur_idx | output | IW | Input position under test |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete (held until next start) |
| fail | output | 1 | Sticky fault result |

## Verification
The assertions check on every cycle that the phases follow each other in their local order: setup step, then load, then marker shift, then the low check, then the high check. They also check that only one phase strobe is active at a time, that each window is exactly `WIN_CYC` cycles long, that `fail` stays set, and that `done` never coincides with `busy`. Only the bench scenarios can show the global counts. These are the rising visit order, the one-time `walk_din`, the total run length for several pattern counts including zero, and which injected fault pulses are ignored. They also show that a start issued mid-run changes nothing.

// File: rtl/xbist_pkg.sv
package xbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GEN  = 3'd1,
    ST_LOAD = 3'd2,
    ST_SEL  = 3'd3,
    ST_CHK0 = 3'd4,
    ST_CHK1 = 3'd5,
    ST_SQW  = 3'd6
  } xb_state_t;
endpackage

// File: rtl/xbist_count.sv
module xbist_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic [W-1:0] val,
  output logic         last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val <= '0;
    else if (clr) val <= '0;
    else if (inc) val <= val + 1'b1;
  end

  assign last = (val == lim);
endmodule

// File: rtl/xbist_fsm.sv
module xbist_fsm
  import xbist_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      zero_pat,
  input  logic      win_last,
  input  logic      idx_last,
  input  logic      pat_last,
  output xb_state_t state
);
  xb_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start && !zero_pat) nxt = ST_GEN;
      ST_GEN:  nxt = ST_LOAD;
      ST_LOAD: nxt = ST_SEL;
      ST_SEL:  nxt = ST_CHK0;
      ST_CHK0: nxt = ST_CHK1;
      ST_CHK1: nxt = ST_SQW;
      ST_SQW: begin
        if (win_last) begin
          if (!idx_last)     nxt = ST_SEL;
          else if (pat_last) nxt = ST_IDLE;
          else               nxt = ST_GEN;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/xbist_seq.sv
module xbist_seq
  import xbist_pkg::*;
#(
  parameter int NUM_IN  = 3,
  parameter int WIN_CYC = 4,
  parameter int PCW     = 8,
  localparam int IW     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int WW     = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [PCW-1:0] pat_count,
  input  logic           fault_flag,
  output logic           lfsr_step,
  output logic           err_clr,
  output logic           pat_load,
  output logic           walk_shift,
  output logic           walk_din,
  output logic           dm_en,
  output logic           chk_drive,
  output logic           chk_val,
  output logic           cap_strobe,
  output logic           upd_strobe,
  output logic           det_en,
  output logic           sq_mode,
  output logic [IW-1:0]  cur_idx,
  output logic           busy,
  output logic           done,
  output logic           fail
);
  xb_state_t      state;
  logic           accept;
  logic           in_sqw;
  logic           win_last, idx_last, pat_last;
  logic           step_idx, step_pat, finish;
  logic [PCW-1:0] pat_lim;
  logic [PCW-1:0] pat_val;
  logic [WW-1:0]  win_val;

  assign accept   = start && (state == ST_IDLE);
  assign in_sqw   = (state == ST_SQW);
  assign step_idx = in_sqw && win_last;
  assign step_pat = step_idx && idx_last;
  assign finish   = step_pat && pat_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pat_lim <= '0;
    else if (accept) pat_lim <= pat_count;
  end

  xbist_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .zero_pat (pat_count == '0),
    .win_last (win_last),
    .idx_last (idx_last),
    .pat_last (pat_last),
    .state    (state)
  );

  xbist_count #(.W(WW)) u_win (
    .clk (clk), .rst_n (rst_n),
    .clr (!in_sqw), .inc (in_sqw),
    .lim (WW'(WIN_CYC - 1)),
    .val (win_val), .last (win_last)
  );

  xbist_count #(.W(IW)) u_idx (
    .clk (clk), .rst_n (rst_n),
    .clr (state == ST_GEN), .inc (step_idx && !idx_last),
    .lim (IW'(NUM_IN - 1)),
    .val (cur_idx), .last (idx_last)
  );

  xbist_count #(.W(PCW)) u_pat (
    .clk (clk), .rst_n (rst_n),
    .clr (state == ST_IDLE), .inc (step_pat),
    .lim (pat_lim - 1'b1),
    .val (pat_val), .last (pat_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      fail <= 1'b0;
    end else if (accept) begin
      done <= (pat_count == '0);
      fail <= 1'b0;
    end else begin
      if (finish)              done <= 1'b1;
      if (in_sqw && fault_flag) fail <= 1'b1;
    end
  end

  always_comb begin
    lfsr_step  = (state == ST_GEN);
    err_clr    = (state == ST_GEN);
    pat_load   = (state == ST_LOAD);
    walk_shift = (state == ST_SEL);
    walk_din   = (state == ST_SEL) && (cur_idx == '0);
    dm_en      = (state == ST_CHK0) || (state == ST_CHK1);
    chk_drive  = dm_en;
    chk_val    = (state == ST_CHK1);
    cap_strobe = (state == ST_CHK0) || in_sqw;
    upd_strobe = in_sqw;
    det_en     = in_sqw;
    sq_mode    = in_sqw;
    busy       = (state != ST_IDLE);
  end
endmodule

// File: rtl/xbist_seq_chk.sv
module xbist_seq_chk #(
  parameter int WIN_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic lfsr_step,
  input logic pat_load,
  input logic walk_shift,
  input logic dm_en,
  input logic chk_val,
  input logic sq_mode,
  input logic busy,
  input logic done,
  input logic fail
);
  logic        prev_sq;
  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sq <= 1'b0;
      run     <= '0;
    end else begin
      prev_sq <= sq_mode;
      if (sq_mode) run <= prev_sq ? run + 1 : 32'd1;
    end
  end

  AST_GEN_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_step |=> pat_load); // R1
  AST_SHIFT_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    walk_shift |=> (dm_en && !chk_val)); // R2
  AST_LOW_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_en && !chk_val) |=> (dm_en && chk_val)); // R3
  AST_HIGH_THEN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_en && chk_val) |=> sq_mode); // R3
  AST_WIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_sq && !sq_mode) |-> (run == WIN_CYC)); // R4
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lfsr_step, pat_load, walk_shift, dm_en, sq_mode})); // R5
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> fail); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
endmodule

bind xbist_seq xbist_seq_chk #(.WIN_CYC(WIN_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .lfsr_step  (lfsr_step),
  .pat_load   (pat_load),
  .walk_shift (walk_shift),
  .dm_en      (dm_en),
  .chk_val    (chk_val),
  .sq_mode    (sq_mode),
  .busy       (busy),
  .done       (done),
  .fail       (fail)
);

// File: tb/tb_xbist_seq.sv
module tb_xbist_seq;
  localparam int CLK_PERIOD = 10;
  localparam int M   = 3;
  localparam int WIN = 4;
  localparam int PCW = 8;
  localparam int IW  = 2;
  localparam int L   = 2 + M * (3 + WIN);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PCW-1:0] pat_count = '0;
  logic fault_flag = 1'b0;
  logic lfsr_step, err_clr, pat_load, walk_shift, walk_din, dm_en;
  logic chk_drive, chk_val, cap_strobe, upd_strobe, det_en, sq_mode;
  logic [IW-1:0] cur_idx;
  logic busy, done, fail;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xbist_seq #(.NUM_IN(M), .WIN_CYC(WIN), .PCW(PCW)) dut (
    .clk (clk), .rst_n (rst_n), .start (start), .pat_count (pat_count),
    .fault_flag (fault_flag), .lfsr_step (lfsr_step), .err_clr (err_clr),
    .pat_load (pat_load), .walk_shift (walk_shift), .walk_din (walk_din),
    .dm_en (dm_en), .chk_drive (chk_drive), .chk_val (chk_val),
    .cap_strobe (cap_strobe), .upd_strobe (upd_strobe), .det_en (det_en),
    .sq_mode (sq_mode), .cur_idx (cur_idx), .busy (busy), .done (done),
    .fail (fail)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [12:0] strobes();
    return {lfsr_step, err_clr, pat_load, walk_shift, walk_din, dm_en,
            chk_drive, chk_val, cap_strobe, upd_strobe, det_en, sq_mode, busy};
  endfunction

  // phase of cycle t: 0 gen, 1 load, 2 sel, 3 chk low, 4 chk high, 5 window
  function automatic int phase_of(input int t, output int idx);
    int o = t % L;
    idx = 0;
    if (o == 0) return 0;
    if (o == 1) return 1;
    idx = (o - 2) / (3 + WIN);
    case ((o - 2) % (3 + WIN))
      0: return 2;
      1: return 3;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic logic [12:0] expect_vec(input int ph, input int idx);
    logic [12:0] v = '0;
    v[0] = 1'b1;
    case (ph)
      0: begin v[12] = 1; v[11] = 1; end
      1: v[10] = 1;
      2: begin v[9] = 1; v[8] = (idx == 0); end
      3: begin v[7] = 1; v[6] = 1; v[4] = 1; end
      4: begin v[7] = 1; v[6] = 1; v[5] = 1; end
      default: begin v[4] = 1; v[3] = 1; v[2] = 1; v[1] = 1; end
    endcase
    return v;
  endfunction

  task automatic run_case(input int p, input int fault_t, input int bstart_t);
    logic exp_fail = 1'b0;
    @(negedge clk);
    pat_count = PCW'(p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pat_count = PCW'(5);
    for (int t = 0; t < p * L; t++) begin
      int idx;
      int ph = phase_of(t, idx);
      string req;
      case (ph)
        0, 1: req = "R1";
        2: req = "R2";
        3, 4: req = "R3";
        default: req = "R4";
      endcase
      check(req, 32'(strobes()), 32'(expect_vec(ph, idx)));
      if (ph >= 2) check("R5 cur_idx", 32'(cur_idx), 32'(idx));
      check("R6 fail", 32'(fail), 32'(exp_fail));
      check("R7 done low while busy", 32'(done), 32'd0);
      fault_flag = (t == fault_t);
      start = (t == bstart_t); // R8: start while busy
      if (t == fault_t && ph == 5) exp_fail = 1'b1;
      @(negedge clk);
      fault_flag = 1'b0;
      start = 1'b0;
    end
    check("R5 R7 busy low at end", 32'(busy), 32'd0);
    check("R7 done at end", 32'(done), 32'd1);
    check("R6 fail at end", 32'(fail), 32'(exp_fail));
    check("R7 no strobes after end", 32'(strobes()), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset strobes", 32'(strobes()), 32'd0);
    check("R7 reset done", 32'(done), 32'd0);
    check("R6 reset fail", 32'(fail), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: zero patterns
    run_case(0, -1, -1);
    // R1 R2 R3 R4 R5: pattern-count sweep
    for (int p = 1; p <= 3; p++) run_case(p, -1, -1);
    // R6: fault during check phase is ignored
    run_case(1, 3, -1);
    // R6 R8: fault inside a window, start mid-run
    run_case(2, 7, 10);
    // R7: new start clears fail (checked at t=0 inside run)
    run_case(1, L + 1, -1);
    // R6: fault in the last window cycle of a pattern
    run_case(1, L - 1, 2);
    repeat (2) @(negedge clk);
    check("R7 done held", 32'(done), 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule